// File: doc/BRIEF.md
# DRAM Cell Model with Parallel Compress-Test Mode

This block is a clock-sampled behavioural model of a small by-four dynamic memory. It has active-low row strobe, column strobe, write enable and output enable inputs, and one multiplexed address bus. On every system clock edge it samples the strobes. Each row-strobe cycle is sorted into one of four kinds: an ordinary access, a column-before-row refresh, a write-and-column-before-row cycle, or a row-only refresh. A test-mode flag is set and cleared from these events.

In normal mode the block behaves as a plain nibble-wide memory. The row address is captured when the row strobe falls, and the column address is captured when the column strobe falls. In test mode the two lowest column bits are ignored, and each I/O lane covers a group of four neighbouring words. A write copies each input bit into the same bit of all four words. A read returns, for each lane, a high level if the four stored bits agree and a low level if they differ, so one access checks sixteen cells.

Data input and output are separate ports, with an output-enable flag in place of a bidirectional pin. A status output gives the test-mode flag, and a two-bit code gives the kind of the last decoded cycle.

Top module: `nibble_dram_tm`

## Requirements
- R1: After reset, testMode is 0, cycleType is 0 and dOutEn is 0.
- R2: When the row strobe is first sampled low while column strobe and write enable are both low, cycleType becomes 2 and testMode becomes 1 on that edge. This also holds when testMode is already 1.
- R3: When the row strobe is first sampled low while the column strobe is low and write enable is high, cycleType becomes 1 and testMode becomes 0.
- R4: If the row strobe goes low with the column strobe high and rises again without the column strobe having fallen, cycleType becomes 3 and testMode becomes 0 on the edge where the row strobe is seen high.
- R5: In normal mode, a column-strobe fall with write enable low stores dIn at the word given by the latched row (upper address bits) and the column on addr at that edge.
- R6: In normal mode, once the column strobe has fallen with write enable high and output enable is low, dOut shows the stored word at the latched row and column, and dOutEn is 1.
- R7: In test mode, a write ignores column bits 1:0 and writes dIn into all four words whose column matches in the upper bits.
- R8: In test mode, a read drives dOut[i] to 1 when bit i of the four grouped words is all 1 or all 0, and to 0 when it is mixed.
- R9: An ordinary read cycle in test mode leaves testMode at 1, and cycleType is 0 for it.
- R10: dOutEn is 0 whenever output enable is high, the column strobe is high, or the current cycle is a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| rasN | input | 1 | Active-low row strobe |
| casN | input | 1 | Active-low column strobe |
| weN | input | 1 | Active-low write enable |
| oeN | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Multiplexed row/column address |
| dIn | input | IO_N | Write data, one bit per I/O lane |
| dOut | output | IO_N | Read data, or per-lane pass/fail in test mode |
| dOutEn | output | 1 | High when dOut is driven (low means high impedance) |
| testMode | output | 1 | Current test-mode flag |
| cycleType | output | 2 | Last decoded cycle: 0 access, 1 refresh, 2 test entry, 3 row-only |

## Verification
The bench uses the defaults ROW_W = 4, COL_W = 4 and IO_N = 4: a 256-word array with four column groups per row. With this size a single group can be filled by a test-mode write, read back word by word in normal mode, altered in one word, and compressed again. This covers both the all-agree and the mixed outcome on particular lanes. Because each row has four groups, the bench can also show that the don't-care column bits do not move the compare onto a neighbouring group.

// File: rtl/nibble_dram_tm_pkg.sv
package nibble_dram_tm_pkg;

  typedef enum logic [1:0] {
    CYC_ACCESS  = 2'd0,
    CYC_REFRESH = 2'd1,
    CYC_TEST    = 2'd2,
    CYC_ROWONLY = 2'd3
  } cycKind_e;

  typedef struct packed {
    logic latchRow;
    logic latchCol;
    logic wrEn;
    logic rdEn;
    logic tmode;
  } dpCtl_t;

endpackage

// File: rtl/nibble_dram_tm_ctrl.sv
module nibble_dram_tm_ctrl
  import nibble_dram_tm_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     rasN,
  input  logic     casN,
  input  logic     weN,
  input  logic     oeN,
  output dpCtl_t   ctl,
  output logic     testMode,
  output cycKind_e cycType
);

  logic rasPrev, casPrev;
  logic inCycle, casSeen, writeCyc;
  logic rasFall, rasRise, casFall, accessOpen;

  assign rasFall    = rasPrev & ~rasN;
  assign rasRise    = ~rasPrev & rasN;
  assign casFall    = casPrev & ~casN;
  assign accessOpen = inCycle && (cycType == CYC_ACCESS) && !rasN;

  always_comb begin
    ctl.latchRow = rasFall && casN;
    ctl.latchCol = accessOpen && casFall;
    ctl.wrEn     = accessOpen && casFall && !weN;
    ctl.rdEn     = accessOpen && casSeen && !writeCyc && !casN && !oeN;
    ctl.tmode    = testMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasPrev  <= 1'b1;
      casPrev  <= 1'b1;
      inCycle  <= 1'b0;
      casSeen  <= 1'b0;
      writeCyc <= 1'b0;
      testMode <= 1'b0;
      cycType  <= CYC_ACCESS;
    end else begin
      rasPrev <= rasN;
      casPrev <= casN;
      if (rasFall) begin
        inCycle  <= 1'b1;
        casSeen  <= 1'b0;
        writeCyc <= 1'b0;
        if (!casN) begin
          if (!weN) begin
            cycType  <= CYC_TEST;
            testMode <= 1'b1;
          end else begin
            cycType  <= CYC_REFRESH;
            testMode <= 1'b0;
          end
        end else begin
          cycType <= CYC_ACCESS;
        end
      end else if (rasRise) begin
        inCycle <= 1'b0;
        casSeen <= 1'b0;
        if (inCycle && cycType == CYC_ACCESS && !casSeen) begin
          cycType  <= CYC_ROWONLY;
          testMode <= 1'b0;
        end
      end else if (ctl.latchCol) begin
        casSeen  <= 1'b1;
        writeCyc <= !weN;
      end
    end
  end

  AST_WCBR_ENTERS: assert property (@(posedge clk) disable iff (!rstN)
    rasFall && !casN && !weN |=> testMode && cycType == CYC_TEST); // R2
  AST_CBR_LEAVES: assert property (@(posedge clk) disable iff (!rstN)
    rasFall && !casN && weN |=> !testMode && cycType == CYC_REFRESH); // R3
  AST_ROWONLY_LEAVES: assert property (@(posedge clk) disable iff (!rstN)
    rasRise && inCycle && cycType == CYC_ACCESS && !casSeen |=> !testMode); // R4
  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !rasFall && !rasRise |=> $stable(testMode)); // R9
  AST_NO_WRITE_READ: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrEn |=> !ctl.rdEn); // R10

endmodule

// File: rtl/nibble_dram_tm_data.sv
module nibble_dram_tm_data
  import nibble_dram_tm_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int IO_N  = 4,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [IO_N-1:0]   dIn,
  input  dpCtl_t            ctl,
  output logic [IO_N-1:0]   dOut,
  output logic              dOutEn
);

  localparam int GRP_W  = 2;
  localparam int GRP_N  = 1 << GRP_W;
  localparam int GSEL_W = COL_W - GRP_W;
  localparam int DEPTH  = 1 << (ROW_W + COL_W);

  logic [IO_N-1:0]  mem [DEPTH];
  logic [ROW_W-1:0] rowQ;
  logic [COL_W-1:0] colQ;
  logic [COL_W-1:0] wrCol;
  logic [IO_N-1:0]  grpWord [GRP_N];
  logic [IO_N-1:0]  allOnes, allZeros;

  assign wrCol = addr[COL_W-1:0];

  always_ff @(posedge clk) begin
    if (ctl.latchRow) rowQ <= addr[ROW_W-1:0];
    if (ctl.latchCol) colQ <= wrCol;
  end

  generate
    for (genvar g = 0; g < GRP_N; g++) begin : g_grp
      always_ff @(posedge clk) begin
        if (ctl.wrEn) begin
          if (ctl.tmode)
            mem[{rowQ, wrCol[COL_W-1:GRP_W], GRP_W'(g)}] <= dIn;
          else if (wrCol[GRP_W-1:0] == GRP_W'(g))
            mem[{rowQ, wrCol}] <= dIn;
        end
      end
      assign grpWord[g] = mem[{rowQ, colQ[COL_W-1:GRP_W], GRP_W'(g)}];
    end
  endgenerate

  always_comb begin
    allOnes  = '1;
    allZeros = '1;
    for (int g = 0; g < GRP_N; g++) begin
      allOnes  = allOnes & grpWord[g];
      allZeros = allZeros & ~grpWord[g];
    end
  end

  assign dOutEn = ctl.rdEn;
  always_comb begin
    if (!ctl.rdEn)      dOut = '0;
    else if (ctl.tmode) dOut = allOnes | allZeros;
    else                dOut = mem[{rowQ, colQ}];
  end

  logic [GSEL_W-1:0] unusedSel;
  assign unusedSel = colQ[COL_W-1:GRP_W];

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk)
    !dOutEn |-> dOut == '0); // R10

endmodule

// File: rtl/nibble_dram_tm.sv
module nibble_dram_tm
  import nibble_dram_tm_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int IO_N  = 4,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [IO_N-1:0]   dIn,
  output logic [IO_N-1:0]   dOut,
  output logic              dOutEn,
  output logic              testMode,
  output logic [1:0]        cycleType
);

  dpCtl_t   ctl;
  cycKind_e cycKind;

  nibble_dram_tm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN),
    .ctl(ctl), .testMode(testMode), .cycType(cycKind)
  );

  nibble_dram_tm_data #(.ROW_W(ROW_W), .COL_W(COL_W), .IO_N(IO_N)) u_data (
    .clk(clk), .addr(addr), .dIn(dIn), .ctl(ctl), .dOut(dOut), .dOutEn(dOutEn)
  );

  assign cycleType = cycKind;

  AST_TRISTATE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (oeN || casN) |-> !dOutEn); // R10
  AST_RESET_NORMAL: assert property (@(posedge clk)
    !rstN |=> !testMode && cycleType == 2'd0); // R1

endmodule

// File: tb/nibble_dram_tm_bench.sv
`timescale 1ns/1ps
module nibble_dram_tm_bench;

  logic       clk = 1'b0;
  logic       rstN, rasN, casN, weN, oeN;
  logic [3:0] addr, dIn, dOut;
  logic       dOutEn, testMode;
  logic [1:0] cycleType;
  int         total = 0, failed = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  nibble_dram_tm u_nibble_dram_tm (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN),
    .addr(addr), .dIn(dIn), .dOut(dOut), .dOutEn(dOutEn),
    .testMode(testMode), .cycleType(cycleType)
  );

  // {row, col, data}
  localparam logic [11:0] VEC [6] = '{
    12'h1_3_A, 12'h1_4_5, 12'h7_0_F, 12'hF_F_0, 12'h2_9_C, 12'h1_2_6
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    rasN = 1; casN = 1; weN = 1; oeN = 1;
  endtask

  task automatic writeCyc(input logic [3:0] row, col, data);
    @(negedge clk); addr = row; rasN = 0;
    @(negedge clk); addr = col; dIn = data; weN = 0; oeN = 0; casN = 0;
    @(negedge clk); check("R10 write hides output", dOutEn, 0);
    rasN = 1; casN = 1; weN = 1; oeN = 1;
    idle();
  endtask

  task automatic readCyc(input logic [3:0] row, col, input logic oe,
                         output logic [3:0] data, output logic en);
    @(negedge clk); addr = row; rasN = 0;
    @(negedge clk); addr = col; weN = 1; oeN = oe; casN = 0;
    @(negedge clk); data = dOut; en = dOutEn;
    rasN = 1; casN = 1; oeN = 1;
    idle();
  endtask

  task automatic casFirst(input logic we);
    @(negedge clk); casN = 0; weN = we;
    @(negedge clk); rasN = 0;
  endtask

  task automatic rowOnly(input logic [3:0] row);
    @(negedge clk); addr = row; rasN = 0;
    @(negedge clk);
    @(negedge clk); rasN = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", total, failed);
      $finish;
    end
  end

  initial begin
    logic [3:0] rd;
    logic       en;
    rstN = 0; rasN = 1; casN = 1; weN = 1; oeN = 1; addr = 0; dIn = 0;
    repeat (3) @(negedge clk);
    check("R1 testMode", testMode, 0);
    check("R1 cycleType", cycleType, 0);
    check("R1 dOutEn", dOutEn, 0);
    rstN = 1;
    idle();

    // table: normal writes, then reads back
    for (int i = 0; i < 6; i++) writeCyc(VEC[i][11:8], VEC[i][7:4], VEC[i][3:0]);
    for (int i = 0; i < 6; i++) begin
      readCyc(VEC[i][11:8], VEC[i][7:4], 1'b0, rd, en);
      check("R5 R6 normal data", rd, VEC[i][3:0]);
      check("R6 output enabled", en, 1);
    end
    check("R6 access cycle code", cycleType, 0);

    // output enable high hides the read
    readCyc(4'h1, 4'h3, 1'b1, rd, en);
    check("R10 oe high", en, 0);

    // enter test mode
    casFirst(1'b0);
    @(negedge clk);
    check("R2 cycleType", cycleType, 2);
    check("R2 testMode", testMode, 1);
    idle(); idle();

    // test-mode write into row 3, column group 2 (cols 8..11), low bits ignored
    writeCyc(4'h3, 4'hA, 4'b1010);
    readCyc(4'h3, 4'h9, 1'b0, rd, en);
    check("R8 all agree", rd, 4'b1111);
    check("R8 enabled", en, 1);
    check("R9 read keeps mode", testMode, 1);
    check("R9 cycle code", cycleType, 0);

    // leave with refresh (we high)
    casFirst(1'b1);
    @(negedge clk);
    check("R3 cycleType", cycleType, 1);
    check("R3 testMode", testMode, 0);
    idle(); idle();

    for (int c = 8; c < 12; c++) begin
      readCyc(4'h3, 4'(c), 1'b0, rd, en);
      check("R7 broadcast word", rd, 4'b1010);
    end
    readCyc(4'h3, 4'h4, 1'b0, rd, en);
    check("R7 neighbour group untouched", rd, 4'h5 & 4'h0);

    // make lane 1 mixed in group 2
    writeCyc(4'h3, 4'hB, 4'b1000);
    casFirst(1'b0);
    @(negedge clk);
    check("R2 enter again", testMode, 1);
    idle(); idle();
    readCyc(4'h3, 4'h8, 1'b0, rd, en);
    check("R8 mixed lane low", rd, 4'b1101);

    // test entry while already in test mode keeps it
    casFirst(1'b0);
    @(negedge clk);
    check("R2 repeat cycleType", cycleType, 2);
    check("R2 repeat testMode", testMode, 1);
    idle(); idle();

    // row-only refresh leaves test mode
    rowOnly(4'h5);
    check("R4 cycleType", cycleType, 3);
    check("R4 testMode", testMode, 0);
    readCyc(4'h3, 4'hB, 1'b0, rd, en);
    check("R4 normal read after exit", rd, 4'b1000);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", total, failed);
    $finish;
  end

endmodule